// File: doc/BRIEF.md
# Tandem Connection Parity Error Accumulator

This block watches the 8-bit interleaved parity of a tandem connection monitoring layer in an optical transport frame. Each frame, a frame-valid strobe presents two bytes: the parity the local datapath computed over the previous frame and the parity byte that arrived in the overhead. The block XORs them. It adds the number of set bits in the result to a bit-error accumulator, and it adds one to a block-error accumulator whenever the two bytes differ at all.

A once-per-second strobe copies both accumulators into cache registers that a processor reads. A mode bit decides whether the accumulators restart after the copy or keep running. Monitoring is suspended while any of several upstream defect indications is active. Out-of-frame and incoming alignment error suspend monitoring only when their enable bits are set. Any counted mismatch also sets a sticky status bit. The status bit is cleared by a write-one pulse and, together with a mask bit, forms an interrupt.

Top module: `tcm_parity_monitor`

## Requirements
- R1: For each accepted frame, the bit-error accumulator grows by the number of ones in (calc_par XOR rx_par). For example, 8'h5A against 8'h1D adds 4.
- R2: For each accepted frame whose two parity bytes differ in at least one bit, the block-error accumulator grows by exactly 1. It does not grow otherwise.
- R3: In a cycle with sec_tick high, bit_cache and blk_cache load the accumulator values held before that cycle's frame. In any other cycle, both caches hold their value.
- R4: With clear_on_xfer = 1, a sec_tick restarts both accumulators. A frame accepted in the same cycle is counted into the new interval, so the following tick reports exactly that frame's contribution.
- R5: With clear_on_xfer = 0, a sec_tick leaves both accumulators running, so later caches show totals that include earlier intervals.
- R6: Neither accumulator wraps. Each stops at its all-ones value: 24 bits for bit errors and 20 bits for block errors by default.
- R7: While any of lof, los, ais, oci, ltc or lck is high, a frame is not accepted. It changes neither accumulator nor the status bit.
- R8: oof blocks acceptance only when oof_gate_en = 1. iae blocks acceptance only when iae_gate_en = 1. With its enable at 0, either input has no effect.
- R9: err_sts becomes 1 in the cycle after an accepted mismatching frame and stays 1 until a cycle with sts_clr high and no new accepted mismatch. A new mismatch in the clearing cycle keeps it set.
- R10: irq equals err_sts AND irq_mask.
- R11: After reset, both caches, err_sts and irq are 0.
- R12: When frame_vld is 0, the parity bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_vld | input | 1 | One frame's parity bytes are present |
| calc_par | input | 8 | Locally computed parity byte |
| rx_par | input | 8 | Received parity byte |
| sec_tick | input | 1 | One-second transfer strobe |
| clear_on_xfer | input | 1 | 1: restart accumulators on transfer; 0: keep them |
| lof | input | 1 | Loss of frame |
| los | input | 1 | Loss of signal |
| ais | input | 1 | Alarm indication signal |
| oci | input | 1 | Open connection indication |
| ltc | input | 1 | Loss of tandem connection |
| lck | input | 1 | Locked indication |
| oof | input | 1 | Out of frame |
| iae | input | 1 | Incoming alignment error |
| oof_gate_en | input | 1 | Lets oof suspend monitoring |
| iae_gate_en | input | 1 | Lets iae suspend monitoring |
| sts_clr | input | 1 | Write-one-to-clear pulse for err_sts |
| irq_mask | input | 1 | Interrupt enable |
| bit_cache | output | 24 | Bit-error count of the last interval |
| blk_cache | output | 20 | Block-error count of the last interval |
| err_sts | output | 1 | Sticky parity error status |
| irq | output | 1 | Masked interrupt |

## Verification
Directed frames check the exact counts first. Single-bit, multi-bit and all-bit mismatches separate a population count from a plain any-difference flag. Equal bytes confirm that a clean frame adds nothing to either accumulator. Frames that coincide with a transfer, in both clear and retain modes, show whether the coinciding error goes into the new interval or the old one. A narrow-width instance is driven past its all-ones value to tell saturation apart from wrap-around. A seeded random mix of defects, gate enables, transfer strobes and clears is then compared cycle by cycle against a bench model.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

   localparam int DEF_N = 8;

   // Bit positions of the defect vector inside the block.
   typedef enum int unsigned {
      D_LOF = 0,
      D_LOS = 1,
      D_AIS = 2,
      D_OCI = 3,
      D_LTC = 4,
      D_LCK = 5,
      D_OOF = 6,
      D_IAE = 7
   } def_idx_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/tpm_defect_gate.sv
module tpm_defect_gate
   import tpm_pkg::*;
(
   input  logic [DEF_N-1:0] defects,
   input  logic             oof_en,
   input  logic             iae_en,
   output logic             pause
);

   logic [DEF_N-1:0] qual;

   always_comb begin
      qual         = '1;
      qual[D_OOF]  = oof_en;
      qual[D_IAE]  = iae_en;
      pause        = |(defects & qual);
   end

endmodule

// File: rtl/tpm_parity_cmp.sv
module tpm_parity_cmp #(
   parameter int BYTE_W = 8,
   parameter int CW     = 4
) (
   input  logic              vld,
   input  logic              pause,
   input  logic [BYTE_W-1:0] calc,
   input  logic [BYTE_W-1:0] rx,
   output logic [CW-1:0]     bit_inc,
   output logic              blk_inc
);

   if (CW < $clog2(BYTE_W + 1)) begin : g_bad_cw
      $error("tpm_parity_cmp: CW too narrow for BYTE_W");
   end

   logic [BYTE_W-1:0] diff;
   logic [CW-1:0]     psum [BYTE_W+1];

   assign diff    = (vld && !pause) ? (calc ^ rx) : '0;
   assign psum[0] = '0;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_pop
      assign psum[i+1] = psum[i] + CW'(diff[i]);
   end

   assign bit_inc = psum[BYTE_W];
   assign blk_inc = |diff;

endmodule

// File: rtl/tpm_sat_accum.sv
module tpm_sat_accum #(
   parameter int W  = 24,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic          clr_mode,
   input  logic [IW-1:0] inc,
   output logic [W-1:0]  acc,
   output logic [W-1:0]  cache
);

   if (IW >= W) begin : g_bad_w
      $error("tpm_sat_accum: increment must be narrower than accumulator");
   end

   logic [W-1:0] base;
   logic [W:0]   sum;
   logic [W-1:0] nxt;

   always_comb begin
      base = (xfer && clr_mode) ? '0 : acc;
      sum  = {1'b0, base} + {{(W + 1 - IW){1'b0}}, inc};
      nxt  = sum[W] ? {W{1'b1}} : sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         cache <= '0;
      end else begin
         acc <= nxt;
         if (xfer) cache <= acc;
      end
   end

   p_cache_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(cache));

   p_cache_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> cache == $past(acc));

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && clr_mode) |=> acc == {{(W - IW){1'b0}}, $past(inc)});

   p_retain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !clr_mode) |=> acc >= $past(acc));

   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer && clr_mode) |=> acc >= $past(acc));

endmodule

// File: rtl/tpm_sticky_irq.sv
module tpm_sticky_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic err,
   input  logic clr,
   input  logic mask,
   output logic sts,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= 1'b0;
      else        sts <= err | (sts & ~clr);
   end

   assign irq = sts & mask;

   p_sts_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> sts);

   p_sts_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !err) |=> !sts);

   p_sts_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts && !clr) |=> sts);

endmodule

// File: rtl/tcm_parity_monitor.sv
module tcm_parity_monitor
   import tpm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int BIT_W  = 24,
   parameter int BLK_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_vld,
   input  logic [BYTE_W-1:0] calc_par,
   input  logic [BYTE_W-1:0] rx_par,
   input  logic              sec_tick,
   input  logic              clear_on_xfer,
   input  logic              lof,
   input  logic              los,
   input  logic              ais,
   input  logic              oci,
   input  logic              ltc,
   input  logic              lck,
   input  logic              oof,
   input  logic              iae,
   input  logic              oof_gate_en,
   input  logic              iae_gate_en,
   input  logic              sts_clr,
   input  logic              irq_mask,
   output logic [BIT_W-1:0]  bit_cache,
   output logic [BLK_W-1:0]  blk_cache,
   output logic              err_sts,
   output logic              irq
);

   localparam int CW = cnt_bits(BYTE_W);

   if (BLK_W < 2) begin : g_bad_blk
      $error("tcm_parity_monitor: BLK_W must be at least 2");
   end

   logic [DEF_N-1:0] defects;
   logic             pause;
   logic [CW-1:0]    bit_inc;
   logic             blk_inc;
   logic [BIT_W-1:0] bit_acc;
   logic [BLK_W-1:0] blk_acc;

   always_comb begin
      defects        = '0;
      defects[D_LOF] = lof;
      defects[D_LOS] = los;
      defects[D_AIS] = ais;
      defects[D_OCI] = oci;
      defects[D_LTC] = ltc;
      defects[D_LCK] = lck;
      defects[D_OOF] = oof;
      defects[D_IAE] = iae;
   end

   tpm_defect_gate u_gate (
      .defects (defects),
      .oof_en  (oof_gate_en),
      .iae_en  (iae_gate_en),
      .pause   (pause)
   );

   tpm_parity_cmp #(.BYTE_W(BYTE_W), .CW(CW)) u_cmp (
      .vld     (frame_vld),
      .pause   (pause),
      .calc    (calc_par),
      .rx      (rx_par),
      .bit_inc (bit_inc),
      .blk_inc (blk_inc)
   );

   tpm_sat_accum #(.W(BIT_W), .IW(CW)) u_bit_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer     (sec_tick),
      .clr_mode (clear_on_xfer),
      .inc      (bit_inc),
      .acc      (bit_acc),
      .cache    (bit_cache)
   );

   tpm_sat_accum #(.W(BLK_W), .IW(1)) u_blk_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer     (sec_tick),
      .clr_mode (clear_on_xfer),
      .inc      (blk_inc),
      .acc      (blk_acc),
      .cache    (blk_cache)
   );

   tpm_sticky_irq u_sts (
      .clk  (clk),
      .rst_n(rst_n),
      .err  (blk_inc),
      .clr  (sts_clr),
      .mask (irq_mask),
      .sts  (err_sts),
      .irq  (irq)
   );

   p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && !sec_tick) |=> ($stable(bit_acc) && $stable(blk_acc)));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_vld && !sec_tick) |=> ($stable(bit_acc) && $stable(blk_acc)));

   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_sts |-> !irq);

endmodule

// File: tb/tcm_parity_monitor_tb.sv
`timescale 1ns/1ps
module tcm_parity_monitor_tb;

   localparam longint MAXB  = (64'd1 << 24) - 1;
   localparam longint MAXK  = (64'd1 << 20) - 1;
   localparam longint SMAXB = 63;
   localparam longint SMAXK = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_vld = 0, sec_tick = 0, clear_on_xfer = 0;
   logic [7:0] calc_par = 0, rx_par = 0;
   logic lof = 0, los = 0, ais = 0, oci = 0, ltc = 0, lck = 0, oof = 0, iae = 0;
   logic oof_gate_en = 0, iae_gate_en = 0, sts_clr = 0, irq_mask = 0;
   logic [23:0] bit_cache;
   logic [19:0] blk_cache;
   logic err_sts, irq;
   logic [5:0] s_bit_cache;
   logic [3:0] s_blk_cache;
   logic s_err_sts, s_irq;

   int n_tests = 0;
   int n_fail  = 0;

   longint m_b = 0, m_k = 0, m_cb = 0, m_ck = 0;
   longint s_b = 0, s_k = 0, s_cb = 0, s_ck = 0;
   bit     m_sts = 0;

   always #2.5 clk = ~clk;

   tcm_parity_monitor u_dut (
      .clk, .rst_n, .frame_vld, .calc_par, .rx_par, .sec_tick, .clear_on_xfer,
      .lof, .los, .ais, .oci, .ltc, .lck, .oof, .iae, .oof_gate_en, .iae_gate_en,
      .sts_clr, .irq_mask, .bit_cache, .blk_cache, .err_sts, .irq
   );

   tcm_parity_monitor #(.BYTE_W(8), .BIT_W(6), .BLK_W(4)) u_dut_small (
      .clk, .rst_n, .frame_vld, .calc_par, .rx_par, .sec_tick, .clear_on_xfer,
      .lof, .los, .ais, .oci, .ltc, .lck, .oof, .iae, .oof_gate_en, .iae_gate_en,
      .sts_clr, .irq_mask, .bit_cache(s_bit_cache), .blk_cache(s_blk_cache),
      .err_sts(s_err_sts), .irq(s_irq)
   );

   function automatic longint acc_next(longint acc, longint inc, bit tick,
                                       bit clrm, longint maxv);
      longint base = (tick && clrm) ? 0 : acc;
      longint s    = base + inc;
      return (s > maxv) ? maxv : s;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // def bits: [0]lof [1]los [2]ais [3]oci [4]ltc [5]lck [6]oof [7]iae
   task automatic step(bit vld, logic [7:0] c, logic [7:0] r, bit tick, bit clrm,
                       logic [7:0] def, bit oen, bit ien, bit sclr, bit msk,
                       string tag);
      bit     paused;
      longint cnt, blk;
      frame_vld = vld; calc_par = c; rx_par = r; sec_tick = tick;
      clear_on_xfer = clrm;
      {iae, oof, lck, ltc, oci, ais, los, lof} = def;
      oof_gate_en = oen; iae_gate_en = ien; sts_clr = sclr; irq_mask = msk;
      @(posedge clk);
      paused = |(def & {ien, oen, 6'h3F});
      cnt    = (vld && !paused) ? $countones(c ^ r) : 0;
      blk    = (cnt != 0) ? 1 : 0;
      if (tick) begin
         m_cb = m_b; m_ck = m_k; s_cb = s_b; s_ck = s_k;
      end
      m_b = acc_next(m_b, cnt, tick, clrm, MAXB);
      m_k = acc_next(m_k, blk, tick, clrm, MAXK);
      s_b = acc_next(s_b, cnt, tick, clrm, SMAXB);
      s_k = acc_next(s_k, blk, tick, clrm, SMAXK);
      m_sts = (blk != 0) || (m_sts && !sclr);
      @(negedge clk);
      chk(tag, "bit_cache", bit_cache, m_cb);
      chk(tag, "blk_cache", blk_cache, m_ck);
      chk(tag, "small bit_cache", s_bit_cache, s_cb);
      chk(tag, "small blk_cache", s_blk_cache, s_ck);
      chk(tag, "err_sts", err_sts, m_sts);
      chk(tag, "irq", irq, m_sts && msk);
   endtask

   task automatic tick_only(bit clrm, string tag);
      step(0, 8'h00, 8'h00, 1, clrm, 8'h00, 0, 0, 0, 0, tag);
   endtask

   task automatic quiet(string tag);
      step(0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, 1, 0, tag);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11", "bit_cache", bit_cache, 0);
      chk("R11", "blk_cache", blk_cache, 0);
      chk("R11", "err_sts", err_sts, 0);
      chk("R11", "irq", irq, 0);

      // R1 / R2: 0x5A vs 0x1D gives 4 bit errors, 1 block error
      step(1, 8'h5A, 8'h1D, 0, 1, 8'h00, 0, 0, 0, 1, "R1");
      tick_only(1, "R2");
      chk("R1", "example bits", bit_cache, 4);
      chk("R2", "example blocks", blk_cache, 1);
      // clean frame and full-byte mismatch
      step(1, 8'hC3, 8'hC3, 0, 1, 8'h00, 0, 0, 1, 0, "R2");
      step(1, 8'hFF, 8'h00, 0, 1, 8'h00, 0, 0, 0, 0, "R1");
      tick_only(1, "R1");
      chk("R1", "full byte bits", bit_cache, 8);
      chk("R2", "full byte blocks", blk_cache, 1);

      // R4: error coinciding with a clearing transfer joins the new interval
      step(1, 8'h03, 8'h00, 0, 1, 8'h00, 0, 0, 0, 0, "R4");
      step(1, 8'h01, 8'h00, 1, 1, 8'h00, 0, 0, 0, 0, "R4");
      chk("R4", "old interval", bit_cache, 2);
      tick_only(1, "R4");
      chk("R4", "new interval bits", bit_cache, 1);
      chk("R4", "new interval blocks", blk_cache, 1);

      // R5: retain mode keeps totals across transfers
      step(1, 8'h06, 8'h00, 0, 0, 8'h00, 0, 0, 0, 0, "R5");
      step(1, 8'h10, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0, "R5");
      tick_only(0, "R5");
      chk("R5", "running bits", bit_cache, 3);
      chk("R5", "running blocks", blk_cache, 2);
      tick_only(1, "R5");
      quiet("R9");

      // R7: each hard defect blocks counting and status
      for (int d = 0; d < 6; d++) begin
         step(1, 8'hF0, 8'h00, 0, 1, 8'(1 << d), 1, 1, 0, 1, "R7");
         chk("R7", "status untouched", err_sts, 0);
      end
      tick_only(1, "R7");
      chk("R7", "no bits counted", bit_cache, 0);

      // R8: conditional gating of oof and iae
      step(1, 8'h01, 8'h00, 0, 1, 8'h40, 1, 0, 0, 0, "R8");
      step(1, 8'h03, 8'h00, 0, 1, 8'h40, 0, 0, 0, 0, "R8");
      step(1, 8'h01, 8'h00, 0, 1, 8'h80, 0, 1, 0, 0, "R8");
      step(1, 8'h0F, 8'h00, 0, 1, 8'h80, 0, 0, 0, 0, "R8");
      tick_only(1, "R8");
      chk("R8", "ungated bits", bit_cache, 6);
      chk("R8", "ungated blocks", blk_cache, 2);

      // R9 / R10: sticky status, clear, set priority, mask
      quiet("R9");
      chk("R9", "cleared", err_sts, 0);
      step(1, 8'h01, 8'h00, 0, 1, 8'h00, 0, 0, 0, 0, "R9");
      chk("R10", "masked irq", irq, 0);
      step(0, 8'h00, 8'h00, 0, 1, 8'h00, 0, 0, 0, 1, "R10");
      chk("R10", "unmasked irq", irq, 1);
      step(1, 8'h80, 8'h00, 0, 1, 8'h00, 0, 0, 1, 1, "R9");
      chk("R9", "set beats clear", err_sts, 1);
      quiet("R9");
      chk("R9", "clear works", err_sts, 0);

      // R12: invalid frame ignored
      tick_only(1, "R12");
      step(0, 8'hAA, 8'h55, 0, 1, 8'h00, 0, 0, 0, 0, "R12");
      chk("R12", "status", err_sts, 0);
      tick_only(1, "R12");
      chk("R12", "no bits", bit_cache, 0);

      // R6: saturation on the narrow instance
      for (int i = 0; i < 20; i++)
         step(1, 8'hFF, 8'h00, 0, 0, 8'h00, 0, 0, 0, 0, "R6");
      tick_only(0, "R6");
      chk("R6", "small bits saturate", s_bit_cache, 63);
      chk("R6", "small blocks saturate", s_blk_cache, 15);
      step(1, 8'hFF, 8'h00, 1, 0, 8'h00, 0, 0, 0, 0, "R6");
      chk("R6", "still saturated", s_bit_cache, 63);
      tick_only(1, "R6");
      tick_only(1, "R6");
      chk("R6", "cleared after sat", s_bit_cache, 0);

      // Seeded random mix
      void'($urandom(32'd20240611));
      for (int blkn = 0; blkn < 8; blkn++) begin
         bit clrm = 1'($urandom % 2);
         bit oen  = 1'($urandom % 2);
         bit ien  = 1'($urandom % 2);
         for (int i = 0; i < 400; i++) begin
            logic [7:0] c   = 8'($urandom);
            logic [7:0] e   = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            logic [7:0] def = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            step(($urandom % 4) != 0, c, c ^ e, ($urandom % 16) == 0, clrm,
                 def, oen, ien, ($urandom % 10) == 0, 1'($urandom % 2), "R3");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule